// File: doc/BRIEF.md
# Serial-Access Byte SRAM Target

This block is the serial front end and storage of a byte-wide static memory that a host reaches over single-lane SPI, clock mode 0. The host pulls the active-low select low, clocks in an 8-bit opcode and then a 24-bit address, both MSB first. After that, data bytes flow into the array, or flow out of it on the serial output. An internal pointer steps after each whole byte. How it steps depends on a transfer-mode register: one byte per access, wrap inside a 32-byte page, or run through the whole address space and roll over from the top address to zero.

The serial pins are oversampled by the block clock `clk`, which must run at least eight times faster than the serial clock. The design clock does all the work. Serial clock edges are found from synchronized copies of the pin. The serial output is driven, with `spi_miso_oe` high, only while a read-type byte is being shifted out. The outside pad turns `spi_miso_oe` low into high impedance. The data path is a bit-serial pin interface, not a stream, so the block has no valid/ready handshake and no back-pressure: the host's serial clock sets the pace.

Top module: `sram_spi_target`

## Requirements
- R1: After reset the transfer mode is single-byte (field value 00) and `spi_miso_oe` is low.
- R2: `spi_miso_oe` stays low during the opcode byte, the three address bytes and all write-data bytes.
- R3: Opcode 0x02 followed by a 24-bit address stores each following complete byte at the pointer. Address bits above ADDR_W (default 17) are ignored.
- R4: Opcode 0x03 followed by a 24-bit address drives the byte at the pointer on `spi_miso`, MSB first. Each bit changes after a serial clock falling edge and is valid at the next rising edge.
- R5: Opcode 0x01 loads the mode field from bits [7:6] of the next byte. Opcode 0x05 returns the field in bits [7:6], with zeros below. Encodings: 00 single byte, 10 page, 01 sequential, 11 behaves as single byte.
- R6: In single-byte mode only one data byte is moved per select. For a write, later clocks leave the memory unchanged. For a read, `spi_miso_oe` drops after the byte.
- R7: In page mode the pointer steps through a 32-byte page. After the last byte of the page it returns to the page's first byte, so bytes outside the page are never touched.
- R8: In sequential mode the pointer steps through the whole space and wraps from 0x1FFFF to 0x00000, for both reads and writes.
- R9: An unrecognized opcode causes no write and no output drive until the select rises.
- R10: A partial data byte pending when the select rises is discarded.
- R11: Raising the select ends any access at any point and releases `spi_miso_oe`. The next falling select starts a fresh opcode.
- R12: The array holds 2**MEM_AW bytes (default 1024). Pointer values alias onto it through their low MEM_AW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low select; frames one access |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High while `spi_miso` should be driven onto the pin |

## Verification
The main path is tried with five access shapes: a lone byte write followed by extra clocks, a read back, a page-mode run that crosses the page end, a sequential run that crosses the top address, and reads that start at both sides of that rollover. Together they tell a pointer that holds apart from one that wraps in a page and one that wraps across the space. A bystander byte sits next to every access boundary and is read back afterwards, which catches any stray write. Unknown opcodes, truncated address or data bytes, and a reserved mode encoding check that partial or ignored traffic changes neither the memory nor the output enable.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  typedef enum logic [1:0] {
    MODE_BYTE  = 2'b00,
    MODE_BURST = 2'b01,
    MODE_PAGE  = 2'b10,
    MODE_RSVD  = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_MODEW,
    PH_MODER,
    PH_SKIP
  } phase_e;

  localparam logic [7:0] OP_MODE_WR = 8'h01;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_MODE_RD = 8'h05;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int         N       = 3,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o
);

  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign pin_o = stg[STAGES-1];

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
  import sram_spi_pkg::*;
#(
  parameter int AW = 17,
  parameter int PW = 5
) (
  input  logic [AW-1:0] ptr_i,
  input  xfer_mode_e    mode_i,
  output logic [AW-1:0] nxt_o
);

  always_comb begin
    case (mode_i)
      MODE_PAGE:  nxt_o = {ptr_i[AW-1:PW], ptr_i[PW-1:0] + 1'b1};
      MODE_BURST: nxt_o = ptr_i + 1'b1;
      default:    nxt_o = ptr_i;
    endcase
  end

endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int MEM_AW = 10,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import sram_spi_pkg::*;
#(
  parameter int AW = 17,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          mosi_s,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic [7:0]    rd_byte,
  input  logic [AW-1:0] nxt_ptr,
  output logic [AW-1:0] ptr_o,
  output xfer_mode_e    mode_o,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          miso,
  output logic          miso_oe
);

  localparam int ADDR_BYTES = 3;

  phase_e     phase;
  logic [2:0] bit_cnt;
  logic [6:0] in_sh;
  logic [1:0] addr_cnt;
  logic       rd_op;
  logic [7:0] out_sh;
  logic [AW-1:0] ptr_q;
  xfer_mode_e mode_q;
  logic       miso_q, oe_q;

  logic       byte_done, streaming, shifting;
  logic [7:0] full_byte, src_byte;

  always_comb begin
    full_byte = {in_sh, mosi_s};
    byte_done = sck_rise && (bit_cnt == 3'd7);
    mem_we    = !cs_n_s && byte_done && (phase == PH_WDATA);
    streaming = (mode_q == MODE_PAGE) || (mode_q == MODE_BURST);
    shifting  = (phase == PH_RDATA) || (phase == PH_MODER);
    src_byte  = (phase == PH_MODER) ? {mode_q, 6'b0} : rd_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      in_sh    <= '0;
      addr_cnt <= '0;
      rd_op    <= 1'b0;
      out_sh   <= '0;
      ptr_q    <= '0;
      mode_q   <= MODE_BYTE;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (cs_n_s) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      addr_cnt <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        in_sh   <= full_byte[6:0];
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            case (full_byte)
              OP_WRITE:   begin phase <= PH_ADDR; rd_op <= 1'b0; end
              OP_READ:    begin phase <= PH_ADDR; rd_op <= 1'b1; end
              OP_MODE_WR: phase <= PH_MODEW;
              OP_MODE_RD: begin phase <= PH_MODER; oe_q <= 1'b1; end
              default:    phase <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            ptr_q    <= AW'({ptr_q, full_byte});
            addr_cnt <= addr_cnt + 1'b1;
            if (addr_cnt == 2'(ADDR_BYTES - 1)) begin
              addr_cnt <= '0;
              phase    <= rd_op ? PH_RDATA : PH_WDATA;
              oe_q     <= rd_op;
            end
          end
          PH_WDATA: begin
            ptr_q <= nxt_ptr;
            if (!streaming) phase <= PH_SKIP;
          end
          PH_RDATA: begin
            ptr_q <= nxt_ptr;
            if (!streaming) begin
              phase <= PH_SKIP;
              oe_q  <= 1'b0;
            end
          end
          PH_MODEW: begin
            mode_q <= xfer_mode_e'(full_byte[7:6]);
            phase  <= PH_SKIP;
          end
          PH_MODER: begin
            phase <= PH_SKIP;
            oe_q  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (sck_fall && shifting) begin
        if (bit_cnt == 3'd0) begin
          miso_q <= src_byte[7];
          out_sh <= {src_byte[6:0], 1'b0};
        end else begin
          miso_q <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign mode_o    = mode_q;
  assign mem_wdata = full_byte;
  assign miso      = miso_q;
  assign miso_oe   = oe_q;

  // R2: no drive while opcode, address or write data are arriving
  p_quiet_inbound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD || phase == PH_ADDR || phase == PH_WDATA) |-> !miso_oe);

  // R7: a page-mode write never moves the pointer out of its page
  p_page_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode_q == MODE_PAGE) |=> (ptr_o[AW-1:PW] == $past(ptr_o[AW-1:PW])));

  // R8: a sequential-mode write advances the pointer by one, rolling over
  p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode_q == MODE_BURST) |=> (ptr_o == AW'($past(ptr_o) + 1'b1)));

  // R6: single-byte mode leaves the data phase after one byte
  p_single_byte_r6: assert property (@(posedge clk) disable iff (!rst_n || cs_n_s)
    (mem_we && mode_q == MODE_BYTE) |=> (phase == PH_SKIP && !mem_we));

endmodule

// File: rtl/sram_spi_target.sv
module sram_spi_target
  import sram_spi_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int MEM_AW   = 10,
  parameter int PAGE_W   = 5,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);

  logic [2:0] pins_s;
  logic       sck_s, cs_n_s, mosi_s, sck_q;
  logic       sck_rise, sck_fall;
  logic [ADDR_W-1:0] ptr, nxt_ptr;
  xfer_mode_e mode;
  logic       mem_we;
  logic [7:0] mem_wdata, rd_byte;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({spi_sck, spi_cs_n, spi_mosi}),
    .pin_o(pins_s)
  );

  assign {sck_s, cs_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  spi_frame_ctl #(.AW(ADDR_W), .PW(PAGE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rd_byte(rd_byte),
    .nxt_ptr(nxt_ptr), .ptr_o(ptr), .mode_o(mode), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  addr_stepper #(.AW(ADDR_W), .PW(PAGE_W)) u_step (
    .ptr_i(ptr), .mode_i(mode), .nxt_o(nxt_ptr)
  );

  byte_store #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .addr(ptr[MEM_AW-1:0]),
    .wdata(mem_wdata), .rdata(rd_byte)
  );

  // R11: once the select is seen high, the output enable is released
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !spi_miso_oe);

  // R11: no memory write while the access is deselected
  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !mem_we);

endmodule

// File: tb/sim_sram_spi_target.sv
module sim_sram_spi_target;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, oe;

  always #5 clk = ~clk;

  sram_spi_target u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(oe)
  );

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   cap = 1'b0, done = 1'b0;
  logic [7:0] mon_sh = '0;
  int   mon_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = tx[7-i];
      half();
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    bits(b, 8);
  endtask

  task automatic start();
    @(negedge clk);
    cs_n = 1'b0;
    half();
  endtask

  task automatic stop();
    half();
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a);
    send(op);
    send(a[23:16]);
    send(a[15:8]);
    send(a[7:0]);
  endtask

  // driver: queue the expectation, then clock the byte out of the design
  task automatic recv(input logic [7:0] e, input string req);
    q.push_back('{val: e, req: req});
    cap = 1'b1;
    bits(8'h00, 8);
    cap = 1'b0;
  endtask

  task automatic oe_low(input string req, input string what);
    half();
    chk(oe == 1'b0, req, what, int'(oe), 0);
  endtask

  // monitor: gathers bits at each rising serial clock, pops and compares
  always @(posedge sck) begin
    if (cap) begin
      if (oe !== 1'b1) begin
        checks++;
        errors++;
        $display("FAIL R4 output enable low during read bit: actual %0b expected 1", oe);
      end
      mon_sh = {mon_sh[6:0], miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R4 unexpected read byte: actual %0h expected none", mon_sh);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(mon_sh === e.val, e.req, "read byte", int'(mon_sh), int'(e.val));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(oe == 1'b0, "R1", "output enable after reset", int'(oe), 0);

    // R1 R5: mode reads back as single-byte
    start(); send(8'h05); recv(8'h00, "R1"); stop();

    // single-byte mode setup: bystanders
    start(); hdr(8'h02, 24'h000011); send(8'h77); stop();
    start(); hdr(8'h02, 24'h000040); send(8'h99); stop();

    // R6 R2: byte write plus extra clocks
    start(); send(8'h02); oe_low("R2", "after opcode");
    send(8'h00); send(8'h00); send(8'h10); oe_low("R2", "after address");
    send(8'hA5); oe_low("R2", "after write data");
    send(8'h5A); stop();
    start(); hdr(8'h03, 24'h000010); recv(8'hA5, "R3"); stop();
    start(); hdr(8'h03, 24'h000011); recv(8'h77, "R6"); bits(8'h00, 8);
    oe_low("R6", "enable after single read byte"); stop();

    // R3: upper address bits ignored
    start(); hdr(8'h02, 24'hFE0020); send(8'h3C); stop();
    start(); hdr(8'h03, 24'h000020); recv(8'h3C, "R3"); stop();

    // R5 R7: page mode
    start(); send(8'h01); send(8'h80); stop();
    start(); send(8'h05); recv(8'h80, "R5"); stop();
    start(); hdr(8'h02, 24'h00003E); send(8'h11); send(8'h22); send(8'h33); stop();
    start(); hdr(8'h03, 24'h00003E); recv(8'h11, "R7"); recv(8'h22, "R7");
    recv(8'h33, "R7"); stop();
    start(); hdr(8'h03, 24'h000020); recv(8'h33, "R7"); stop();
    start(); hdr(8'h03, 24'h000040); recv(8'h99, "R7"); stop();

    // R8 R12: sequential mode across the top
    start(); send(8'h01); send(8'h40); stop();
    start(); hdr(8'h02, 24'h01FFFE);
    send(8'hB0); send(8'hB1); send(8'hB2); send(8'hB3); stop();
    start(); hdr(8'h03, 24'h000000); recv(8'hB2, "R8"); recv(8'hB3, "R8"); stop();
    start(); hdr(8'h03, 24'h01FFFF); recv(8'hB1, "R8"); recv(8'hB2, "R8"); stop();
    start(); hdr(8'h03, 24'h0003FF); recv(8'hB1, "R12"); stop();

    // R9: unknown opcode
    start(); hdr(8'h02, 24'h000050); send(8'h44); stop();
    start(); send(8'hAB); send(8'h02); send(8'h00); send(8'h00);
    send(8'h50); send(8'hEE); oe_low("R9", "enable after unknown opcode"); stop();
    start(); hdr(8'h03, 24'h000050); recv(8'h44, "R9"); stop();

    // R10: partial trailing byte
    start(); hdr(8'h02, 24'h000060); send(8'h00); send(8'h56); stop();
    start(); hdr(8'h02, 24'h000060); send(8'h12); bits(8'hFF, 5); stop();
    start(); hdr(8'h03, 24'h000060); recv(8'h12, "R10"); recv(8'h56, "R10"); stop();

    // R11: abort mid-address and mid-read
    start(); send(8'h02); send(8'h00); stop();
    start(); send(8'h05); recv(8'h40, "R11"); stop();
    start(); hdr(8'h03, 24'h000060); bits(8'h00, 4); half(); cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(oe == 1'b0, "R11", "enable after select rise", int'(oe), 0);
    repeat (6) @(negedge clk);

    // R5: reserved encoding acts as single byte
    start(); send(8'h01); send(8'hC0); stop();
    start(); send(8'h05); recv(8'hC0, "R5"); stop();
    start(); hdr(8'h03, 24'h000060); recv(8'h12, "R5");
    oe_low("R5", "enable after reserved-mode byte"); stop();

    chk(q.size() == 0, "R4", "pending expectations", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule